// File: doc/BRIEF.md
# Debug Identification and Status Register Window

This block is a small memory-mapped register window for a processor's debug unit. It sits on a simple 32-bit register bus and exposes two registers. One holds a fixed chip identification word loaded at reset. The other holds two sticky debug event flags. Hardware event pulses set the flags, and software clears them by writing ones. Each access is checked for width and offset. An illegal access produces an error response and changes no state.

A bus transaction is a single-cycle strobe, either `acc_rd` or `acc_wr`, with `acc_addr`, `acc_size` and, for writes, `acc_wdata`. The block answers one cycle later with `rsp_valid`, `rsp_err` and `rsp_rdata`. The window starts at parameter `WIN_BASE` and is `WIN_BYTES` long. Addresses outside the window get no response at all.

The access path is a small state machine with three states. `S_IDLE` waits for a strobe. On a strobe it moves to `S_ACK` when the access is legal, or to `S_FAULT` when it is not. `S_ACK` and `S_FAULT` each last one cycle and drive the response. From either one the machine returns to `S_IDLE`, or, when a new strobe is present, it moves straight to the next `S_ACK` or `S_FAULT`.

Top module: `dbg_regwin`

## Requirements
- R1: After reset the identification register reads as parameter `CHIP_ID`, and the status register reads as 0.
- R2: Every access must have `acc_size` == 2 (4 bytes). Any other size returns `rsp_err`=1 and has no effect on either register.
- R3: The size check has priority. An access with a bad size at an unmapped offset still reports the error with `rsp_rdata`=0, and it has no effect.
- R4: Offset 0x0 is the identification register and offset 0x8 is the status register. Every other offset inside the window, including 0x4, returns `rsp_err`=1 with `rsp_rdata`=0.
- R5: A 32-bit write to offset 0x0 returns `rsp_err`=0 and leaves the identification value unchanged.
- R6: A 32-bit write to offset 0x8 clears status bit 2 and/or bit 3 wherever the corresponding `acc_wdata` bit is 1. A 0 in the write data leaves the bit unchanged.
- R7: Status bits other than 2 and 3 always read as 0, and writing them has no effect.
- R8: A pulse on `evt_set[0]` sets status bit 2, and a pulse on `evt_set[1]` sets status bit 3. If a set and a clear of the same bit occur in the same cycle, the bit ends up set.
- R9: A strobe produces `rsp_valid`=1 exactly one cycle later, with `rsp_err` and `rsp_rdata` valid in that cycle. Write responses have `rsp_rdata`=0.
- R10: An address outside [WIN_BASE, WIN_BASE+WIN_BYTES) produces no response, and the registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| acc_addr | input | 32 | byte address |
| acc_rd | input | 1 | read strobe |
| acc_wr | input | 1 | write strobe |
| acc_size | input | 2 | log2 of access bytes |
| acc_wdata | input | 32 | write data |
| evt_set | input | 2 | status set pulses (bit0 to status bit 2, bit1 to status bit 3) |
| rsp_valid | output | 1 | response valid |
| rsp_err | output | 1 | bus error |
| rsp_rdata | output | 32 | read data |

## Verification
A wrong sticky flag shows up at the next read of offset 0x8. The bench therefore reads the status register after every stimulus, so any corruption appears within two cycles. A faulty decode or a wrong priority shows as a wrong `rsp_err` or a nonzero `rsp_rdata` on the response cycle itself. The bench sweeps every word offset and every size, at both reads and writes, so each cell of the decode table is covered. A lost identification word shows as a mismatch when offset 0x0 is read after a write to it.

// File: rtl/dbg_regwin_pkg.sv
package dbg_regwin_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ACK   = 2'd1,
        S_FAULT = 2'd2
    } win_state_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ID   = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_t;

    localparam logic [1:0] SIZE_WORD = 2'd2;
endpackage

// File: rtl/dbg_addr_decode.sv
module dbg_addr_decode
    import dbg_regwin_pkg::*;
#(
    parameter logic [31:0] WIN_BASE  = 32'hFFE0_5000,
    parameter int          WIN_BYTES = 16,
    parameter int          ID_OFF    = 0,
    parameter int          STAT_OFF  = 8
) (
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    output logic        in_win,
    output logic        size_ok,
    output reg_sel_t    sel
);
    localparam logic [31:0] WIN_LEN = 32'(WIN_BYTES);

    logic [31:0] off;

    always_comb begin
        off     = addr - WIN_BASE;
        in_win  = (addr >= WIN_BASE) && (off < WIN_LEN);
        size_ok = (size == SIZE_WORD);
        sel     = SEL_NONE;
        if (off == 32'(ID_OFF)) begin
            sel = SEL_ID;
        end else if (off == 32'(STAT_OFF)) begin
            sel = SEL_STAT;
        end
    end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg #(
    parameter int          NUM_EVT = 2,
    parameter int          EVT_LSB = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_set,
    input  logic               clr_en,
    input  logic [31:0]        clr_data,
    output logic [31:0]        value
);
    logic [NUM_EVT-1:0] flags;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (evt_set[g]) begin
                flags[g] <= 1'b1;
            end else if (clr_en && clr_data[EVT_LSB+g]) begin
                flags[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        value = '0;
        value[EVT_LSB +: NUM_EVT] = flags;
    end
endmodule

// File: rtl/dbg_regwin.sv
module dbg_regwin
    import dbg_regwin_pkg::*;
#(
    parameter logic [31:0] WIN_BASE  = 32'hFFE0_5000,
    parameter int          WIN_BYTES = 16,
    parameter logic [31:0] CHIP_ID   = 32'h27C8_50CB
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] acc_addr,
    input  logic        acc_rd,
    input  logic        acc_wr,
    input  logic [1:0]  acc_size,
    input  logic [31:0] acc_wdata,
    input  logic [1:0]  evt_set,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata
);
    localparam int NUM_EVT = 2;

    logic       in_win, size_ok;
    reg_sel_t   sel;
    logic       strobe, legal;
    logic [31:0] id_q, stat_val;
    logic [31:0] rd_mux, rdata_q;
    win_state_t state_q, state_d;

    dbg_addr_decode #(.WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_dec (
        .addr(acc_addr), .size(acc_size),
        .in_win(in_win), .size_ok(size_ok), .sel(sel)
    );

    assign strobe = (acc_rd || acc_wr) && in_win;
    assign legal  = size_ok && (sel != SEL_NONE);

    dbg_status_reg #(.NUM_EVT(NUM_EVT), .EVT_LSB(2)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
        .clr_en(strobe && acc_wr && legal && (sel == SEL_STAT)),
        .clr_data(acc_wdata), .value(stat_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) id_q <= CHIP_ID;
    end

    always_comb begin
        unique case (sel)
            SEL_ID:   rd_mux = id_q;
            SEL_STAT: rd_mux = stat_val;
            default:  rd_mux = '0;
        endcase
    end

    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE, S_ACK, S_FAULT: begin
                if (strobe) state_d = legal ? S_ACK : S_FAULT;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (strobe && acc_rd && legal) ? rd_mux : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            S_ACK:   begin rsp_valid = 1'b1; rsp_rdata = rdata_q; end
            S_FAULT: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/dbg_regwin_chk.sv
module dbg_regwin_chk #(
    parameter logic [31:0] WIN_BASE  = 32'hFFE0_5000,
    parameter int          WIN_BYTES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] acc_addr,
    input logic        acc_rd,
    input logic        acc_wr,
    input logic [1:0]  acc_size,
    input logic [1:0]  evt_set,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata
);
    logic hit;
    logic past_ok;
    assign hit = (acc_rd || acc_wr) && (acc_addr >= WIN_BASE)
                 && (acc_addr - WIN_BASE < 32'(WIN_BYTES));

    always_ff @(posedge clk) past_ok <= rst_n;

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> rsp_valid);                                          // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        rsp_valid |-> $past(hit));                                   // R10
    AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && acc_size != 2'd2) |=> rsp_err);                      // R2
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'd0));                           // R3
    AST_HOLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && acc_addr == WIN_BASE + 32'd4) |=> rsp_err);          // R4
    AST_WR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && acc_wr && !acc_rd) |=> (rsp_rdata == 32'd0));        // R9
endmodule

bind dbg_regwin dbg_regwin_chk #(.WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd),
    .acc_wr(acc_wr), .acc_size(acc_size), .evt_set(evt_set),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/dbg_regwin_tb.sv
module dbg_regwin_tb;
    localparam logic [31:0] BASE = 32'hFFE0_5000;
    localparam logic [31:0] ID   = 32'h27C8_50CB;

    logic clk = 0, rst_n = 0;
    logic [31:0] acc_addr = 0, acc_wdata = 0;
    logic acc_rd = 0, acc_wr = 0;
    logic [1:0] acc_size = 2, evt_set = 0;
    logic rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    int checks = 0, errors = 0;
    logic [31:0] model_stat = 0;

    always #2.5 clk = ~clk;

    dbg_regwin #(.WIN_BASE(BASE), .WIN_BYTES(16), .CHIP_ID(ID)) u_dut (.*);

    task automatic chk(string r, logic [33:0] act, logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic v, output logic e,
                          output logic [31:0] d);
        @(negedge clk);
        acc_addr = a; acc_size = sz; acc_wdata = wd; acc_rd = !wr; acc_wr = wr;
        @(negedge clk);
        acc_rd = 0; acc_wr = 0;
        v = rsp_valid; e = rsp_err; d = rsp_rdata;
    endtask

    task automatic expect_acc(string r, logic wr, logic [31:0] off, logic [1:0] sz,
                              logic [31:0] wd);
        logic v, e; logic [31:0] d;
        logic exp_e; logic [31:0] exp_d;
        exp_e = (sz != 2) || !(off == 0 || off == 8);
        exp_d = 0;
        if (!exp_e && !wr) exp_d = (off == 0) ? ID : model_stat;
        access(wr, BASE + off, sz, wd, v, e, d);
        if (!exp_e && wr && off == 8) model_stat &= ~(wd & 32'hC);
        chk(r, {v, e, d}, {1'b1, exp_e, exp_d});
    endtask

    task automatic pulse(logic [1:0] ev);
        @(negedge clk); evt_set = ev;
        @(negedge clk); evt_set = 0;
        if (ev[0]) model_stat[2] = 1;
        if (ev[1]) model_stat[3] = 1;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic v, e; logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R9 idle", {1'b0, rsp_valid, 32'd0}, 34'd0);
        expect_acc("R1 id", 0, 0, 2, 0);
        expect_acc("R1 stat", 0, 8, 2, 0);
        for (int off = 0; off < 16; off += 4)
            for (int sz = 0; sz < 4; sz++)
                for (int w = 0; w < 2; w++) begin
                    pulse(2'b11);
                    expect_acc((sz != 2) ? "R2 R3 sweep" : "R4 R5 R6 sweep",
                               w[0], off, sz[1:0], 32'hFFFF_FFFF);
                    expect_acc("R2 R5 R7 readback", 0, 8, 2, 0);
                    expect_acc("R5 id intact", 0, 0, 2, 0);
                end
        pulse(2'b11);
        expect_acc("R6 clear bit2", 1, 8, 2, 32'h4);
        expect_acc("R6 bit3 kept", 0, 8, 2, 0);
        expect_acc("R7 no-op bits", 1, 8, 2, 32'hFFFF_FFF3);
        expect_acc("R7 readback", 0, 8, 2, 0);
        // R8: set and clear in same cycle, set wins
        @(negedge clk);
        acc_addr = BASE + 8; acc_size = 2; acc_wdata = 32'hC; acc_wr = 1; evt_set = 2'b11;
        @(negedge clk);
        acc_wr = 0; evt_set = 0;
        chk("R8 wr resp", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b0, 32'd0});
        model_stat = 32'hC;
        expect_acc("R8 set wins", 0, 8, 2, 0);
        pulse(2'b10); expect_acc("R6 clr3", 1, 8, 2, 32'h8);
        expect_acc("R8 evt1 only", 0, 8, 2, 0);
        // R10: outside window
        access(1, BASE + 16, 2, 32'hC, v, e, d);
        chk("R10 above", {v, e, d}, 34'd0);
        access(1, BASE - 4, 2, 32'hC, v, e, d);
        chk("R10 below", {v, e, d}, 34'd0);
        expect_acc("R10 unchanged", 0, 8, 2, 0);
        // R9 back-to-back strobes
        @(negedge clk);
        acc_addr = BASE; acc_rd = 1; acc_size = 2;
        @(negedge clk);
        chk("R9 b2b 1", {rsp_valid, rsp_err, rsp_rdata}, {2'b10, ID});
        acc_addr = BASE + 4;
        @(negedge clk);
        acc_rd = 0;
        chk("R9 b2b 2", {rsp_valid, rsp_err, rsp_rdata}, {2'b11, 32'd0});
        @(negedge clk);
        chk("R9 drop", {1'b0, rsp_valid, 32'd0}, 34'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule